// File: doc/BRIEF.md
# Add/Subtract Flag-Setting ALU

This block is the integer add/subtract datapath of an execution unit. A single carry-propagate adder serves plain add, subtract, add and subtract that take the carry flag as carry-in, and the two conditional-compare forms. Subtraction is formed by inverting the second operand and injecting a carry of one. A size select chooses between a narrow width (32 bits by default) and the full width (64 bits by default). In narrow mode the upper operand bits are ignored and the result is returned zero-extended.

The four condition flags N, Z, C and V are held in a register inside the block. An add or subtract loads them on a valid strobe only when set-flags is asserted. A conditional compare first evaluates a 4-bit condition code against the held flags. If the condition passes, the flags take the outcome of the comparison. If it fails, they are loaded from a 4-bit fallback immediate.

Top module: `addsub_flag_alu`

## Requirements
- R1: With op_i = 2'b00 (add), result_o is op_a_i + op_b_i + cin modulo the selected width. cin is 0, or the held C flag when use_carry_i is 1.
- R2: With op_i = 2'b01 (subtract), result_o is op_a_i + ~op_b_i + cin modulo the selected width. cin is 1, or the held C flag when use_carry_i is 1.
- R3: With size64_i = 0, only bits [31:0] of the operands affect the result and the flags, and result_o[63:32] is zero.
- R4: A flag load from the adder sets N to the top bit of the result at the selected width, and sets Z when that result is all zeros.
- R5: The adder's C is 1 exactly when the unsigned sum of both operand terms and the carry-in exceeds the maximum unsigned value of the selected width.
- R6: The adder's V is 1 exactly when the two addend terms share a sign bit and the result's sign bit differs from it.
- R7: For add and subtract, flags_o changes only at a clock edge where valid_i and set_flags_i are both 1. In every other cycle it holds, including every cycle with valid_i = 0.
- R8: With op_i = 2'b10 (compare) or 2'b11 (compare-negated), a valid strobe loads the flags whatever set_flags_i is, provided the condition passes. Compare loads the flags of op_a + ~op_b + 1; compare-negated loads the flags of op_a + op_b + 0. use_carry_i has no effect on either.
- R9: For a compare whose condition fails, the valid strobe loads flags_o from nzcv_imm_i.
- R10: The condition is evaluated on the held flags. cond_i[3:1] selects the base test: 0 Z, 1 C, 2 N, 3 V, 4 C and not Z, 5 N equals V, 6 not Z and N equals V, 7 true. cond_i[0] = 1 inverts the test, except for code 4'b1111, which is always true.
- R11: While rst_ni is low, flags_o is 4'b0000. flags_o packs N, Z, C and V at bits 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction strobe |
| size64_i | input | 1 | 1 selects full width, 0 selects narrow width |
| op_i | input | 2 | 00 add, 01 subtract, 10 compare, 11 compare-negated |
| use_carry_i | input | 1 | Take carry-in from the held C flag (add/subtract only) |
| set_flags_i | input | 1 | Flag update enable for add/subtract |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| cond_i | input | 4 | Condition code for compares |
| nzcv_imm_i | input | 4 | Fallback flags for a failed compare condition |
| result_o | output | 64 | Sum, zero-extended in narrow mode |
| flags_o | output | 4 | Held flags {N,Z,C,V} |

## Verification
The bench builds the block at its default widths: a 64-bit full width over a 32-bit narrow width. Both carry-out positions are therefore exercised, at bit 64 and at bit 32. The 32-bit boundary is what lets garbage in the operands' upper halves show that narrow mode ignores it. At these widths, directed sums such as all-ones plus one and 0x7FFFFFFF plus one reach unsigned carry and signed overflow exactly. A sweep over all 16 flag patterns and all 16 condition codes covers every branch of the condition evaluation.

// File: rtl/addsub_alu_pkg.sv
package addsub_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CCMP = 2'b10,
    OP_CCMN = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import addsub_alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  nzcv_t      flags_i,
  output logic       pass_o
);
  logic base;

  always_comb begin
    unique case (cond_i[3:1])
      3'd0: base = flags_i.z;
      3'd1: base = flags_i.c;
      3'd2: base = flags_i.n;
      3'd3: base = flags_i.v;
      3'd4: base = flags_i.c & ~flags_i.z;
      3'd5: base = (flags_i.n == flags_i.v);
      3'd6: base = ~flags_i.z & (flags_i.n == flags_i.v);
      default: base = 1'b1;
    endcase
  end

  // low bit inverts, except the all-ones code which stays true
  assign pass_o = (cond_i[0] && (cond_i != 4'hF)) ? ~base : base;
endmodule

// File: rtl/alu_adder.sv
module alu_adder
  import addsub_alu_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] a_i,
  input  logic [WIDE_W-1:0] b_i,
  input  logic              invert_b_i,
  input  logic              cin_i,
  output logic [WIDE_W-1:0] sum_o,
  output nzcv_t             flags_o
);
  localparam int EXT_W = WIDE_W + 1;
  localparam int PAD_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0] mask, a_m, b_m, res;
  logic [EXT_W-1:0]  sum_ext;
  logic              sa, sb, sr, co;

  generate
    if (PAD_W > 0) begin : g_mask
      assign mask = wide_i ? {WIDE_W{1'b1}} : {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};
    end else begin : g_mask_flat
      assign mask = {WIDE_W{1'b1}};
    end
  endgenerate

  assign a_m     = a_i & mask;
  assign b_m     = (invert_b_i ? ~b_i : b_i) & mask;
  assign sum_ext = {1'b0, a_m} + {1'b0, b_m} + EXT_W'(cin_i);
  assign res     = sum_ext[WIDE_W-1:0] & mask;

  assign sa = wide_i ? a_m[WIDE_W-1] : a_m[NARROW_W-1];
  assign sb = wide_i ? b_m[WIDE_W-1] : b_m[NARROW_W-1];
  assign sr = wide_i ? res[WIDE_W-1] : res[NARROW_W-1];
  // operands are masked, so the narrow carry lands in bit NARROW_W
  assign co = wide_i ? sum_ext[WIDE_W] : sum_ext[NARROW_W];

  assign sum_o     = res;
  assign flags_o.n = sr;
  assign flags_o.z = (res == '0);
  assign flags_o.c = co;
  assign flags_o.v = (sa == sb) && (sr != sa);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import addsub_alu_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  nzcv_t d_i,
  output nzcv_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/addsub_flag_alu.sv
module addsub_flag_alu
  import addsub_alu_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              size64_i,
  input  logic [1:0]        op_i,
  input  logic              use_carry_i,
  input  logic              set_flags_i,
  input  logic [WIDE_W-1:0] op_a_i,
  input  logic [WIDE_W-1:0] op_b_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        nzcv_imm_i,
  output logic [WIDE_W-1:0] result_o,
  output logic [3:0]        flags_o
);
  alu_op_e op;
  nzcv_t   flags_q, add_flags, flags_d;
  logic    is_cmp, invert_b, cin, cond_pass, load;

  assign op       = alu_op_e'(op_i);
  assign is_cmp   = (op == OP_CCMP) || (op == OP_CCMN);
  assign invert_b = (op == OP_SUB) || (op == OP_CCMP);

  always_comb begin
    if (is_cmp)           cin = (op == OP_CCMP);
    else if (use_carry_i) cin = flags_q.c;
    else                  cin = (op == OP_SUB);
  end

  alu_adder #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_adder (
    .wide_i     (size64_i),
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .invert_b_i (invert_b),
    .cin_i      (cin),
    .sum_o      (result_o),
    .flags_o    (add_flags)
  );

  alu_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .pass_o  (cond_pass)
  );

  assign flags_d = (is_cmp && !cond_pass) ? nzcv_t'(nzcv_imm_i) : add_flags;
  assign load    = valid_i && (is_cmp || set_flags_i);

  alu_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (flags_d),
    .q_o    (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/addsub_flag_alu_chk.sv
module addsub_flag_alu_chk #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              size64_i,
  input logic [1:0]        op_i,
  input logic              set_flags_i,
  input logic [3:0]        cond_i,
  input logic [3:0]        nzcv_imm_i,
  input logic [WIDE_W-1:0] result_o,
  input logic [3:0]        flags_o
);
  assert_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !size64_i |-> (result_o[WIDE_W-1:NARROW_W] == '0));

  assert_zflag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && set_flags_i && !op_i[1] |=> flags_o[2] == ($past(result_o) == '0));

  assert_nflag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && set_flags_i && !op_i[1]
    |=> flags_o[3] == $past(size64_i ? result_o[WIDE_W-1] : result_o[NARROW_W-1]));

  assert_hold_noset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !op_i[1] && !set_flags_i |=> $stable(flags_o));

  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));

  // EQ with Z clear fails, so the fallback must load
  assert_fallback_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i[1] && (cond_i == 4'b0000) && !flags_o[2]
    |=> flags_o == $past(nzcv_imm_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_R11: assert (flags_o == 4'b0000);
    end
  end
endmodule

bind addsub_flag_alu addsub_flag_alu_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .size64_i    (size64_i),
  .op_i        (op_i),
  .set_flags_i (set_flags_i),
  .cond_i      (cond_i),
  .nzcv_imm_i  (nzcv_imm_i),
  .result_o    (result_o),
  .flags_o     (flags_o)
);

// File: tb/addsub_flag_alu_tb_top.sv
module addsub_flag_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i, size64_i, use_carry_i, set_flags_i;
  logic [1:0]  op_i;
  logic [63:0] op_a_i, op_b_i, result_o;
  logic [3:0]  cond_i, nzcv_imm_i, flags_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl_flags;

  always #4 clk_i = ~clk_i;

  addsub_flag_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .size64_i(size64_i),
    .op_i(op_i), .use_carry_i(use_carry_i), .set_flags_i(set_flags_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .cond_i(cond_i), .nzcv_imm_i(nzcv_imm_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !(cy && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      default: return 1'b1;
    endcase
  endfunction

  // returns {result, nzcv}
  function automatic logic [67:0] model(input bit w64, input logic [1:0] op,
      input logic [63:0] a, input logic [63:0] b, input bit usec, input logic [3:0] f);
    logic [63:0] m, aa, bb, r;
    logic [64:0] s;
    bit sub, cin, sa, sb, sr;
    int msb;
    m   = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    msb = w64 ? 63 : 31;
    sub = (op == 2'b01) || (op == 2'b10);
    aa  = a & m;
    bb  = (sub ? ~b : b) & m;
    if (op[1]) cin = (op == 2'b10);
    else       cin = usec ? f[1] : sub;
    s  = {1'b0, aa} + {1'b0, bb} + {64'd0, cin};
    r  = s[63:0] & m;
    sa = aa[msb]; sb = bb[msb]; sr = r[msb];
    return {r, sr, (r == 64'd0), (s > {1'b0, m}), ((sa == sb) && (sr != sa))};
  endfunction

  task automatic do_op(input bit w64, input logic [1:0] op, input logic [63:0] a,
      input logic [63:0] b, input bit usec, input bit setf, input logic [3:0] c,
      input logic [3:0] imm, input string rtag, input string ftag);
    logic [67:0] e;
    logic [3:0]  nf;
    size64_i = w64; op_i = op; op_a_i = a; op_b_i = b; use_carry_i = usec;
    set_flags_i = setf; cond_i = c; nzcv_imm_i = imm; valid_i = 1'b1;
    e = model(w64, op, a, b, usec, mdl_flags);
    if (op[1]) nf = cond_ok(c, mdl_flags) ? e[3:0] : imm;
    else       nf = setf ? e[3:0] : mdl_flags;
    #1;
    check(result_o === e[67:4], rtag, result_o, e[67:4]);
    @(posedge clk_i);
    #1;
    check(flags_o === nf, ftag, {60'd0, flags_o}, {60'd0, nf});
    mdl_flags = nf;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] ra, rb;
    logic [1:0]  rop;
    bit          rw, ru, rs, pass;
    logic [3:0]  rc, ri;
    string       rt, ft;
    void'($urandom(32'h5EED_1234));
    rst_ni = 1'b0; valid_i = 1'b0; size64_i = 1'b1; op_i = 2'b00;
    use_carry_i = 1'b0; set_flags_i = 1'b0; op_a_i = '0; op_b_i = '0;
    cond_i = '0; nzcv_imm_i = '0; mdl_flags = 4'b0000;
    repeat (3) @(posedge clk_i);
    #1;
    check(flags_o === 4'b0000, "R11", {60'd0, flags_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(flags_o === 4'b0000, "R11", {60'd0, flags_o}, 64'd0);
    @(negedge clk_i);

    // R5: unsigned carry at both widths
    do_op(1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 0, 0, "R1", "R5");
    do_op(0, 2'b00, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 0, 0, "R1", "R5");
    // R1: add with held carry (C=1 from previous)
    do_op(1, 2'b00, 64'd10, 64'd20, 1, 0, 0, 0, "R1", "R7");
    // R6: signed overflow at both widths
    do_op(0, 2'b00, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 1, 0, 0, "R1", "R6");
    do_op(1, 2'b00, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 1, 0, 0, "R1", "R6");
    // R2: subtract, subtract with carry
    do_op(1, 2'b01, 64'd5, 64'd7, 0, 1, 0, 0, "R2", "R4");
    do_op(1, 2'b01, 64'd9, 64'd4, 1, 1, 0, 0, "R2", "R5");
    do_op(1, 2'b01, 64'd9, 64'd4, 1, 1, 0, 0, "R2", "R5");
    // R3: upper halves are garbage in narrow mode
    do_op(0, 2'b00, 64'hDEAD_BEEF_0000_0001, 64'h1234_5678_0000_0002, 0, 1, 0, 0, "R3", "R3");
    do_op(0, 2'b01, 64'hFFFF_0000_0000_0003, 64'h0F0F_0F0F_0000_0003, 0, 1, 0, 0, "R3", "R3");
    // R7: set_flags low keeps flags
    do_op(1, 2'b01, 64'd1, 64'd2, 0, 0, 0, 0, "R2", "R7");
    // R8: compare ignores use_carry and set_flags
    do_op(1, 2'b10, 64'd3, 64'd3, 1, 0, 4'hE, 4'h0, "R8", "R8");
    do_op(1, 2'b11, 64'd3, 64'hFFFF_FFFF_FFFF_FFFD, 1, 0, 4'hF, 4'h0, "R8", "R8");
    // R9: EQ fails when Z clear
    do_op(1, 2'b00, 64'd1, 64'd1, 0, 1, 0, 0, "R1", "R4");
    do_op(1, 2'b10, 64'd8, 64'd8, 0, 0, 4'h0, 4'hA, "R8", "R9");
    // idle cycle holds flags (R7)
    valid_i = 1'b0; set_flags_i = 1'b1; op_i = 2'b00; op_a_i = 64'd0; op_b_i = 64'd0;
    @(posedge clk_i);
    #1;
    check(flags_o === mdl_flags, "R7", {60'd0, flags_o}, {60'd0, mdl_flags});
    @(negedge clk_i);

    // R10: every flag pattern against every condition code
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        do_op(1, 2'b01, 64'd0, 64'd0, 0, 1, 0, 0, "R2", "R4");
        do_op(1, 2'b10, 64'd0, 64'd0, 0, 0, 4'h1, 4'(p), "R8", "R9");
        do_op(1, 2'b10, 64'd0, 64'd0, 0, 0, 4'(c), 4'b1001, "R8", "R10");
      end
    end

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      rw  = 1'($urandom);
      rop = 2'($urandom);
      ru  = 1'($urandom);
      rs  = 1'($urandom);
      rc  = 4'($urandom);
      ri  = 4'($urandom);
      ra  = {$urandom, $urandom};
      rb  = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) rb = ~ra;
      pass = cond_ok(rc, mdl_flags);
      rt = rop[1] ? "R8" : (rop[0] ? "R2" : "R1");
      if (rop[1]) ft = pass ? "R8" : "R9";
      else        ft = rs ? "R4" : "R7";
      do_op(rw, rop, ra, rb, ru, rs, rc, ri, rt, ft);
    end

    valid_i = 1'b0;
    finish_run();
  end
endmodule